// File: doc/BRIEF.md
# Operand Cache Tag and Data Array Controller

This block owns the storage of a direct-mapped operand cache: a tag array of 512 entries and a 16 KB data store of 32-bit words. Lookup for ordinary loads and stores happens elsewhere. This block exposes both arrays to software through two memory-mapped request ports. The tag port reads and writes one line's tag and flag word. The data port reads and writes one longword of the data store.

Overwriting a tag that belongs to a line which is both valid and modified first sends that line's 32 bytes out to external memory as an 8-beat burst. The tag port's acknowledge is held back until the burst has completed. A separate invalidate input drops the valid and modified flags of every line at once, with no write-back.

The controller is a single state machine with five states:
- ST_IDLE accepts requests.
- ST_FLUSH streams the burst.
- ST_INSTALL writes the tag that was held back.
- ST_TAG_RESP and ST_DAT_RESP each return a one-cycle acknowledge.

The transitions are:
- ST_IDLE to ST_TAG_RESP: a tag read, an ignored associative write, or a tag write with no flush needed.
- ST_IDLE to ST_FLUSH: a tag write that hits a valid, modified line.
- ST_IDLE to ST_DAT_RESP: a data access.
- ST_FLUSH to ST_INSTALL: on the final beat handshake.
- ST_INSTALL to ST_TAG_RESP: unconditional.
- Both response states back to ST_IDLE.

When both request inputs are high in the same cycle, the tag request is served first.

Top module: `ocache_array_ctrl`

## Requirements
- R1: After reset, every line is invalid and clean with a zero tag: a tag read of any line returns 0x00000000, and no burst is issued.
- R2: A tag write stores value bits 28:10 as the tag, bit 1 as the modified flag and bit 0 as the valid flag. A tag read returns that word with all other bits zero (the written value ANDed with 0x1FFFFC03). The line is selected by tag_addr[13:5]; tag_addr bits 4:0 do not change the selection.
- R3: A data access reads or writes the 32-bit word at word index dat_addr[13:2]. The 4096 words are all distinct, so the first and last words do not alias.
- R4: A tag write with tag_addr[3] = 1 is an associative write. It is acknowledged but changes no tag or flag and starts no burst.
- R5: A non-associative tag write to a line whose valid and modified flags are both 1 issues exactly 8 beats, with wb_last high only on the 8th. wb_addr is the line base {3'b000, old tag bits 28:10, line index bits 4:0, 5'b00000}. The beats carry the line's words in ascending order, word 0 first.
- R6: During such a flush, tag_ack stays low. It rises two cycles after the final beat handshake, after which the new tag word is installed. The data store contents are unchanged by the flush.
- R7: A tag write to a line that is not both valid and modified issues no burst.
- R8: A one-cycle pulse on inv_all clears the valid and modified flags of every line and keeps the tag bits. It issues no burst, either at the pulse or on a later write to an invalidated line.
- R9: While wb_valid is high and wb_ready is low, wb_addr and wb_data hold their values until the beat is taken.
- R10: A request that needs no flush is acknowledged with a one-cycle pulse in the cycle after it is accepted, and the read data is valid with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_req | input | 1 | Tag-array access request, held until tag_ack |
| tag_we | input | 1 | 1 = write, 0 = read |
| tag_addr | input | 14 | Access address; bits 13:5 pick the line, bit 3 marks an associative write |
| tag_wdata | input | 32 | Tag word to write |
| tag_rdata | output | 32 | Tag word read back |
| tag_ack | output | 1 | One-cycle completion pulse for the tag port |
| dat_req | input | 1 | Data-array access request, held until dat_ack |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_addr | input | 14 | Byte address; bits 13:2 pick the word |
| dat_wdata | input | 32 | Word to write |
| dat_rdata | output | 32 | Word read back |
| dat_ack | output | 1 | One-cycle completion pulse for the data port |
| inv_all | input | 1 | Clear the valid and modified flags of every line |
| wb_valid | output | 1 | A write-back beat is offered |
| wb_ready | input | 1 | External memory takes the beat |
| wb_last | output | 1 | Marks the 8th beat |
| wb_addr | output | 32 | Line base address of the burst |
| wb_data | output | 32 | Beat data word |

## Verification
Wrong flag state shows up in one of three ways: as a burst that should not start, as a missing burst, or as a tag read whose low two bits disagree with the flag history the bench has built. Each of these appears one cycle after the tag request is accepted. A mistaken line index or tag slice in the write-back path is visible directly on wb_addr from the first beat. A wrong beat counter shows as misordered or extra words, or as a misplaced wb_last, within the 8-beat window. A faulty state sequence moves the acknowledge away from the exact cycle counts given in R6 and R10.

// File: rtl/ocache_pkg.sv
package ocache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_INSTALL,
        ST_TAG_RESP,
        ST_DAT_RESP
    } ocs_state_t;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/ocache_tag_store.sv
module ocache_tag_store #(
    parameter int unsigned LINES = 512,
    parameter int unsigned TAG_W = 19,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic             inv_all
);

    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_mem[i] <= '0;
            end
        end else begin
            if (inv_all) begin
                valid_q <= '0;
                dirty_q <= '0;
            end
            if (wr_en) begin
                tag_mem[wr_idx] <= wr_tag;
                valid_q[wr_idx] <= wr_valid;
                dirty_q[wr_idx] <= wr_dirty;
            end
        end
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // R8
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !wr_en) |=> (valid_q == '0 && dirty_q == '0));

endmodule

// File: rtl/ocache_data_store.sv
module ocache_data_store #(
    parameter int unsigned WORDS = 4096,
    localparam int unsigned AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [31:0]   rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [31:0]   rdata_b
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/ocache_wb_burst.sv
module ocache_wb_burst #(
    parameter int unsigned BEATS  = 8,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              wb_ready,
    output logic              wb_valid,
    output logic              wb_last,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              done
);

    logic              active_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            addr_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            addr_q   <= base_addr;
        end else if (active_q && wb_ready) begin
            if (cnt_q == BEAT_W'(BEATS - 1)) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wb_valid = active_q;
    assign wb_last  = active_q && (cnt_q == BEAT_W'(BEATS - 1));
    assign wb_addr  = addr_q;
    assign beat_idx = cnt_q;
    assign done     = active_q && wb_ready && wb_last;

    // R9
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(beat_idx)));

    // R5
    burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wb_valid);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !wb_valid);

endmodule

// File: rtl/ocache_array_ctrl.sv
module ocache_array_ctrl #(
    parameter int unsigned LINES      = 512,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned TAG_LSB    = 10,
    parameter int unsigned TAG_MSB    = 28,
    parameter int unsigned ASSOC_BIT  = 3,
    parameter int unsigned ADDR_W     = 32,
    localparam int unsigned IDX_W   = $clog2(LINES),
    localparam int unsigned OFF_W   = $clog2(LINE_BYTES),
    localparam int unsigned CPU_AW  = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_req,
    input  logic              tag_we,
    input  logic [CPU_AW-1:0] tag_addr,
    input  logic [31:0]       tag_wdata,
    output logic [31:0]       tag_rdata,
    output logic              tag_ack,
    input  logic              dat_req,
    input  logic              dat_we,
    input  logic [CPU_AW-1:0] dat_addr,
    input  logic [31:0]       dat_wdata,
    output logic [31:0]       dat_rdata,
    output logic              dat_ack,
    input  logic              inv_all,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic              wb_last,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_data
);
    import ocache_pkg::*;

    localparam int unsigned TAG_W   = TAG_MSB - TAG_LSB + 1;
    localparam int unsigned WORDS   = LINES * LINE_BYTES / WORD_BYTES;
    localparam int unsigned WAW     = $clog2(WORDS);
    localparam int unsigned BEATS   = LINE_BYTES / WORD_BYTES;
    localparam int unsigned BEAT_W  = $clog2(BEATS);
    localparam int unsigned PIDX_W  = TAG_LSB - OFF_W;
    localparam int unsigned HI_W    = ADDR_W - TAG_MSB - 1;

    ocs_state_t state_q, state_d;

    logic [IDX_W-1:0]  req_idx, lat_idx_q, wr_idx;
    logic [31:0]       lat_val_q, wr_val;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid, rd_dirty;
    logic              assoc, line_dirty, tag_accept, dat_accept;
    logic              tag_wr_en, flush_start, burst_done;
    logic [ADDR_W-1:0] flush_base;
    logic [BEAT_W-1:0] beat_idx;
    logic [31:0]       tag_word, dat_word;
    logic [31:0]       tag_rdata_q, dat_rdata_q;
    logic              dat_wr_en;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{tag_addr[OFF_W-1:0], dat_addr[1:0]};

    assign req_idx    = tag_addr[CPU_AW-1:OFF_W];
    assign assoc      = tag_addr[ASSOC_BIT];
    assign line_dirty = rd_valid && rd_dirty;
    assign tag_accept = (state_q == ST_IDLE) && tag_req;
    assign dat_accept = (state_q == ST_IDLE) && !tag_req && dat_req;
    assign dat_wr_en  = dat_accept && dat_we;

    // --- state register ---
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // --- next state ---
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tag_req) begin
                    if (tag_we && !assoc && line_dirty) begin
                        state_d = ST_FLUSH;
                    end else begin
                        state_d = ST_TAG_RESP;
                    end
                end else if (dat_req) begin
                    state_d = ST_DAT_RESP;
                end
            end
            ST_FLUSH: begin
                if (burst_done) begin
                    state_d = ST_INSTALL;
                end
            end
            ST_INSTALL:  state_d = ST_TAG_RESP;
            ST_TAG_RESP: state_d = ST_IDLE;
            ST_DAT_RESP: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // --- outputs ---
    always_comb begin
        tag_ack = (state_q == ST_TAG_RESP);
        dat_ack = (state_q == ST_DAT_RESP);
    end

    // --- tag write control ---
    assign flush_start = tag_accept && tag_we && !assoc && line_dirty;
    assign tag_wr_en   = (tag_accept && tag_we && !assoc && !line_dirty)
                       || (state_q == ST_INSTALL);
    assign wr_idx      = (state_q == ST_INSTALL) ? lat_idx_q : req_idx;
    assign wr_val      = (state_q == ST_INSTALL) ? lat_val_q : tag_wdata;

    always_comb begin
        flush_base = '0;
        flush_base[TAG_MSB:TAG_LSB]  = rd_tag;
        flush_base[TAG_LSB-1:OFF_W]  = req_idx[PIDX_W-1:0];
    end

    always_comb begin
        tag_word = '0;
        tag_word[TAG_MSB:TAG_LSB] = rd_tag;
        tag_word[1]               = rd_dirty;
        tag_word[0]               = rd_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_idx_q   <= '0;
            lat_val_q   <= '0;
            tag_rdata_q <= '0;
            dat_rdata_q <= '0;
        end else begin
            if (tag_accept) begin
                lat_idx_q <= req_idx;
                lat_val_q <= tag_wdata;
                if (!tag_we) begin
                    tag_rdata_q <= tag_word;
                end
            end
            if (dat_accept && !dat_we) begin
                dat_rdata_q <= dat_word;
            end
        end
    end

    assign tag_rdata = tag_rdata_q;
    assign dat_rdata = dat_rdata_q;

    ocache_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .wr_en    (tag_wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_val[TAG_MSB:TAG_LSB]),
        .wr_valid (wr_val[0]),
        .wr_dirty (wr_val[1]),
        .inv_all  (inv_all)
    );

    ocache_data_store #(
        .WORDS (WORDS)
    ) u_data (
        .clk     (clk),
        .we      (dat_wr_en),
        .waddr   (dat_addr[CPU_AW-1:2]),
        .wdata   (dat_wdata),
        .raddr_a (dat_addr[CPU_AW-1:2]),
        .rdata_a (dat_word),
        .raddr_b ({lat_idx_q, beat_idx}),
        .rdata_b (wb_data)
    );

    ocache_wb_burst #(
        .BEATS  (BEATS),
        .ADDR_W (ADDR_W)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (flush_start),
        .base_addr (flush_base),
        .wb_ready  (wb_ready),
        .wb_valid  (wb_valid),
        .wb_last   (wb_last),
        .wb_addr   (wb_addr),
        .beat_idx  (beat_idx),
        .done      (burst_done)
    );

    // R6
    no_ack_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (!tag_ack && !dat_ack));

    // R4
    assoc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_accept && tag_we && assoc) |=> (tag_ack && !wb_valid));

    // R7
    clean_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_accept && tag_we && !line_dirty) |=> !wb_valid);

    // R5
    flush_addr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_addr[OFF_W-1:0] == '0 && wb_addr[ADDR_W-1:TAG_MSB+1] == HI_W'(0)));

endmodule

// File: tb/sim_ocache_array_ctrl.sv
module sim_ocache_array_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tag_req = 1'b0, tag_we = 1'b0, dat_req = 1'b0, dat_we = 1'b0;
    logic [13:0] tag_addr = '0, dat_addr = '0;
    logic [31:0] tag_wdata = '0, dat_wdata = '0;
    logic [31:0] tag_rdata, dat_rdata, wb_addr, wb_data;
    logic        tag_ack, dat_ack, wb_valid, wb_last;
    logic        inv_all = 1'b0, wb_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic [31:0] bq_addr [8];
    logic [31:0] bq_data [8];
    logic        bq_last [8];

    always #4 clk = ~clk;

    ocache_array_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .tag_req(tag_req), .tag_we(tag_we), .tag_addr(tag_addr), .tag_wdata(tag_wdata),
        .tag_rdata(tag_rdata), .tag_ack(tag_ack),
        .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .dat_ack(dat_ack),
        .inv_all(inv_all),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_last(wb_last),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    typedef struct packed {
        logic [1:0]  op;     // 0 data write, 1 data read, 2 tag write, 3 tag read
        logic [13:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 14'h0004, 32'h0000_00A1, 32'h0},
        '{2'd1, 14'h0004, 32'h0,         32'h0000_00A1},
        '{2'd0, 14'h3FFC, 32'h0000_00B2, 32'h0},
        '{2'd1, 14'h3FFC, 32'h0,         32'h0000_00B2},
        '{2'd1, 14'h0004, 32'h0,         32'h0000_00A1},
        '{2'd2, 14'h0020, 32'hE001_2345, 32'h0},
        '{2'd3, 14'h0020, 32'h0,         32'h0001_2001},
        '{2'd3, 14'h003C, 32'h0,         32'h0001_2001},
        '{2'd2, 14'h3FE0, 32'h1FFF_FC02, 32'h0},
        '{2'd3, 14'h3FE0, 32'h0,         32'h1FFF_FC02},
        '{2'd3, 14'h0040, 32'h0,         32'h0000_0000}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit is_tag, input bit we, input logic [13:0] a,
                          input logic [31:0] wd, input bit stall,
                          output logic [31:0] rd, output int lat, output int nb);
        bit held;
        logic [31:0] ha, hd;
        @(negedge clk);
        if (is_tag) begin
            tag_req = 1'b1; tag_we = we; tag_addr = a; tag_wdata = wd;
        end else begin
            dat_req = 1'b1; dat_we = we; dat_addr = a; dat_wdata = wd;
        end
        wb_ready = 1'b1;
        lat = 0; nb = 0; held = 0; rd = '0; ha = '0; hd = '0;
        forever begin
            @(negedge clk);
            lat++;
            if (held && wb_valid) begin
                chk(wb_addr == ha && wb_data == hd, "R9", wb_data, hd);
            end
            held = 0;
            if (tag_ack || dat_ack) begin
                rd = is_tag ? tag_rdata : dat_rdata;
                break;
            end
            if (lat > 300) begin
                chk(1'b0, "R6", 32'(lat), 32'd0);
                break;
            end
            if (wb_valid) begin
                wb_ready = stall ? ((lat % 2) == 1) : 1'b1;
                if (wb_ready) begin
                    if (nb < 8) begin
                        bq_addr[nb] = wb_addr;
                        bq_data[nb] = wb_data;
                        bq_last[nb] = wb_last;
                    end
                    nb++;
                end else begin
                    held = 1; ha = wb_addr; hd = wb_data;
                end
            end
        end
        tag_req = 1'b0; dat_req = 1'b0; tag_we = 1'b0; dat_we = 1'b0; wb_ready = 1'b1;
    endtask

    task automatic check_burst(input logic [31:0] exp_addr, input int nb);
        chk(nb == 8, "R5", 32'(nb), 32'd8);
        for (int k = 0; k < 8; k++) begin
            chk(bq_addr[k] == exp_addr, "R5", bq_addr[k], exp_addr);
            chk(bq_data[k] == 32'hC0DE_0000 + 32'(k), "R5", bq_data[k], 32'hC0DE_0000 + 32'(k));
            chk(bq_last[k] == (k == 7), "R5", 32'(bq_last[k]), 32'(k == 7));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int lat, nb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        access(1, 0, 14'h00A0, 32'h0, 0, rd, lat, nb);
        chk(rd == 32'h0, "R1", rd, 32'h0);
        chk(nb == 0, "R1", 32'(nb), 32'd0);

        // R2 R3 R10: vector table
        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].op[1], !VECS[i].op[0], VECS[i].addr, VECS[i].wdata, 0, rd, lat, nb);
            chk(lat == 1 && nb == 0, "R10", 32'(lat), 32'd1);
            if (VECS[i].op[0]) begin
                chk(rd == VECS[i].exp, VECS[i].op[1] ? "R2" : "R3", rd, VECS[i].exp);
            end
        end

        // R4: associative write ignored
        access(1, 1, 14'h0028, 32'h0ABC_DC03, 0, rd, lat, nb);
        chk(nb == 0 && lat == 1, "R4", 32'(nb), 32'd0);
        access(1, 0, 14'h0020, 32'h0, 0, rd, lat, nb);
        chk(rd == 32'h0001_2001, "R4", rd, 32'h0001_2001);

        // R7: dirty-but-invalid and valid-but-clean lines do not flush
        access(1, 1, 14'h3FE0, 32'h0000_0001, 0, rd, lat, nb);
        chk(nb == 0, "R7", 32'(nb), 32'd0);
        access(1, 1, 14'h0020, 32'h0000_3C03, 0, rd, lat, nb);
        chk(nb == 0, "R7", 32'(nb), 32'd0);

        for (int k = 0; k < 8; k++) begin
            access(0, 1, 14'h0020 + 14'(4 * k), 32'hC0DE_0000 + 32'(k), 0, rd, lat, nb);
        end

        // R5 R6: flush of a valid modified line
        access(1, 1, 14'h0020, 32'h0000_0001, 0, rd, lat, nb);
        check_burst(32'h0000_3C20, nb);
        chk(lat == 10, "R6", 32'(lat), 32'd10);
        access(1, 0, 14'h0020, 32'h0, 0, rd, lat, nb);
        chk(rd == 32'h0000_0001, "R6", rd, 32'h0000_0001);
        access(0, 0, 14'h0028, 32'h0, 0, rd, lat, nb);
        chk(rd == 32'hC0DE_0002, "R6", rd, 32'hC0DE_0002);

        // R9: flush with back-pressure
        access(1, 1, 14'h0020, 32'hFFFF_FFFF, 0, rd, lat, nb);
        chk(nb == 0, "R7", 32'(nb), 32'd0);
        access(1, 1, 14'h0020, 32'h0000_0000, 1, rd, lat, nb);
        check_burst(32'h1FFF_FC20, nb);
        chk(lat > 10, "R9", 32'(lat), 32'd11);

        // R8: global invalidate
        access(1, 1, 14'h0060, 32'h0040_0003, 0, rd, lat, nb);
        access(1, 1, 14'h3FE0, 32'h1FFF_FC03, 0, rd, lat, nb);
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        chk(!wb_valid, "R8", 32'(wb_valid), 32'd0);
        access(1, 0, 14'h0060, 32'h0, 0, rd, lat, nb);
        chk(rd == 32'h0040_0000, "R8", rd, 32'h0040_0000);
        access(1, 0, 14'h3FE0, 32'h0, 0, rd, lat, nb);
        chk(rd == 32'h1FFF_FC00, "R8", rd, 32'h1FFF_FC00);
        access(1, 1, 14'h0060, 32'h0000_0401, 0, rd, lat, nb);
        chk(nb == 0 && lat == 1, "R8", 32'(nb), 32'd0);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule